// File: doc/BRIEF.md
# Vectored-Interrupt Machine CSR Slice

This block holds the machine-mode control and status registers that a core needs when a core-local vectored interrupt controller takes over its interrupts. It holds the trap-vector register and its mode field, the legacy enable and pending registers, the machine status bits, the exception PC, the cause register, the per-mode active-level register and the level threshold. It also provides a next-interrupt register that lets a handler move straight on to a queued interrupt.

When the trap-vector mode field holds binary 11, the controller mode is active. In that mode the legacy enable and pending registers read as zero and ignore writes. On an interrupt-entry strobe the block saves the current level and the interrupt id in the cause register, captures the PC and stacks the enable bit. On a return strobe it restores the saved level. A read of the next-interrupt register compares the arbiter's best pending request against the saved level and the threshold. If the request wins, the block takes it in at once and sends a clear strobe back to the arbiter.

Top module: `vic_csr_unit`

## Requirements
- R1: Trap-vector register at 0x305. Bits 31:6 hold the table base and bits 5:2 read zero. The mode in bits 1:0 accepts only 00 and 11. A write with 01 or 10 still updates the base but keeps the old mode. `modeActive` is high exactly when the mode is 11.
- R2: Legacy enable register at 0x304 (32 bits). In controller mode it reads zero and a write leaves the stored value unchanged. That stored value reads back once the mode returns to 00.
- R3: Legacy pending register at 0x344 behaves the same way as the enable register in R2.
- R4: Level register at 0xFB1. The machine active level sits in bits 31:24 and the user level in bits 7:0; the user level is always zero here. Address 0xCB1 is a user view that returns only bits 7:0. Writes to either address are ignored.
- R5: An entry strobe updates four things, visible from the next cycle. Cause (0x342) becomes bit 31 = 1, bits 23:16 = the previous active level, and the low id bits = the entry id. The exception PC (0x341) becomes the entry PC with bit 0 cleared. In the status register (0x300), bit 7 takes the old bit 3 and bit 3 clears; bits 12:11 always read 11. The active level becomes the entry level.
- R6: A return strobe restores the active level from cause bits 23:16. It also sets status bit 3 from bit 7 and then sets bit 7 to 1.
- R7: Threshold register at 0x347 is 8 bits wide and ignores the upper write bits. Entry and return leave it unchanged.
- R8: A read of 0x345 returns base + 4×id when all of these hold: controller mode is active, the best request is valid, and its level is greater than both cause bits 23:16 and the threshold. Otherwise the read returns 0.
- R9: A winning read of 0x345 raises `ackValid` with `ackId` = the request id in the same cycle. From the next cycle the active level equals the request level and the cause id equals the request id. A losing read changes nothing.
- R10: After reset, the trap-vector, threshold, level, cause, enable and pending registers are zero, and the status register reads 0x1800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrAddr | input | 12 | CSR address |
| csrWrEn | input | 1 | CSR write strobe |
| csrWData | input | 32 | CSR write data |
| csrRdEn | input | 1 | CSR read strobe (triggers next-interrupt side effect) |
| csrRData | output | 32 | CSR read data, same cycle |
| trapEn | input | 1 | Interrupt entry strobe |
| trapLevel | input | 8 | Level of the interrupt being entered |
| trapId | input | ID_W | Id of the interrupt being entered |
| trapPc | input | 32 | PC to save on entry |
| retEn | input | 1 | Interrupt return strobe |
| bestValid | input | 1 | Arbiter has a pending request |
| bestLevel | input | 8 | Level of the best pending request |
| bestId | input | ID_W | Id of the best pending request |
| modeActive | output | 1 | Controller mode selected |
| epcOut | output | 32 | Saved exception PC |
| ackValid | output | 1 | Next-interrupt taken; clear its edge-pending bit |
| ackId | output | ID_W | Id to clear |

## Verification
Read data, `ackValid` and `ackId` are combinational, so they are due in the same cycle as the read strobe. Every register update from a write, an entry strobe, a return or a winning next-interrupt read appears one clock later. The bench drives each operation at a falling edge and samples combinational results 1 ns later, before the rising edge. It checks register effects with a read in the following cycle, so each check lands exactly one register stage after its stimulus.

// File: rtl/vic_csr_pkg.sv
package vic_csr_pkg;
  localparam int XLEN  = 32;
  localparam int LVL_W = 8;

  localparam logic [11:0] ADDR_STATUS = 12'h300;
  localparam logic [11:0] ADDR_IE     = 12'h304;
  localparam logic [11:0] ADDR_TVEC   = 12'h305;
  localparam logic [11:0] ADDR_EPC    = 12'h341;
  localparam logic [11:0] ADDR_CAUSE  = 12'h342;
  localparam logic [11:0] ADDR_IP     = 12'h344;
  localparam logic [11:0] ADDR_NEXT   = 12'h345;
  localparam logic [11:0] ADDR_THRESH = 12'h347;
  localparam logic [11:0] ADDR_LVL    = 12'hFB1;
  localparam logic [11:0] ADDR_ULVL   = 12'hCB1;

  localparam logic [1:0] MODE_BASIC = 2'b00;
  localparam logic [1:0] MODE_VEC   = 2'b11;

  typedef struct packed {
    logic wrTvec;
    logic wrIe;
    logic wrIp;
    logic wrStatus;
    logic wrEpc;
    logic wrCause;
    logic wrThresh;
    logic trapFire;
    logic retFire;
    logic nxtHit;
    logic nxtFire;
  } csrStrobe_t;
endpackage

// File: rtl/vic_csr_ctrl.sv
module vic_csr_ctrl
  import vic_csr_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic [11:0]      csrAddr,
  input  logic             csrWrEn,
  input  logic             csrRdEn,
  input  logic             trapEn,
  input  logic             retEn,
  input  logic             bestValid,
  input  logic [LVL_W-1:0] bestLevel,
  input  logic [ID_W-1:0]  bestId,
  input  logic             modeActive,
  input  logic [LVL_W-1:0] prevLevel,
  input  logic [LVL_W-1:0] threshLevel,
  output csrStrobe_t       strb,
  output logic             ackValid,
  output logic [ID_W-1:0]  ackId
);
  logic quiet;
  logic wrSel;

  always_comb begin
    // entry and return own the cycle; software accesses wait
    quiet = !trapEn && !retEn;
    wrSel = csrWrEn && quiet;

    strb          = '0;
    strb.wrTvec   = wrSel && (csrAddr == ADDR_TVEC);
    strb.wrIe     = wrSel && (csrAddr == ADDR_IE) && !modeActive;
    strb.wrIp     = wrSel && (csrAddr == ADDR_IP) && !modeActive;
    strb.wrStatus = wrSel && (csrAddr == ADDR_STATUS);
    strb.wrEpc    = wrSel && (csrAddr == ADDR_EPC);
    strb.wrCause  = wrSel && (csrAddr == ADDR_CAUSE);
    strb.wrThresh = wrSel && (csrAddr == ADDR_THRESH);
    strb.trapFire = trapEn;
    strb.retFire  = retEn && !trapEn;
    strb.nxtHit   = modeActive && bestValid &&
                    (bestLevel > prevLevel) && (bestLevel > threshLevel);
    strb.nxtFire  = csrRdEn && quiet && (csrAddr == ADDR_NEXT) && strb.nxtHit;

    ackValid = strb.nxtFire;
    ackId    = strb.nxtFire ? bestId : '0;
  end
endmodule

// File: rtl/vic_csr_dpath.sv
module vic_csr_dpath
  import vic_csr_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strb,
  input  logic [11:0]      csrAddr,
  input  logic [XLEN-1:0]  csrWData,
  input  logic [LVL_W-1:0] trapLevel,
  input  logic [ID_W-1:0]  trapId,
  input  logic [XLEN-1:0]  trapPc,
  input  logic [LVL_W-1:0] bestLevel,
  input  logic [ID_W-1:0]  bestId,
  output logic [XLEN-1:0]  csrRData,
  output logic             modeActive,
  output logic [LVL_W-1:0] curLevel,
  output logic [LVL_W-1:0] prevLevel,
  output logic [LVL_W-1:0] threshLevel,
  output logic [XLEN-1:0]  epcOut
);
  localparam int BASE_LSB = 6;
  localparam int ID_PAD   = 16 - ID_W;
  localparam int OFS_PAD  = XLEN - ID_W - 2;

  logic [XLEN-1:BASE_LSB] tvecBase;
  logic [1:0]             tvecMode;
  logic [XLEN-1:0]        legacyQ [2];
  logic                   mieQ, mpieQ;
  logic [XLEN-1:0]        epcQ;
  logic                   causeIrq;
  logic [LVL_W-1:0]       causePil;
  logic [ID_W-1:0]        causeId;
  logic [LVL_W-1:0]       levelQ;
  logic [LVL_W-1:0]       threshQ;

  // trap-vector register; mode field keeps only supported encodings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tvecBase <= '0;
      tvecMode <= MODE_BASIC;
    end else if (strb.wrTvec) begin
      tvecBase <= csrWData[XLEN-1:BASE_LSB];
      if (csrWData[1:0] == MODE_BASIC || csrWData[1:0] == MODE_VEC)
        tvecMode <= csrWData[1:0];
    end
  end

  // legacy enable (0) and pending (1) stores share one shape
  for (genvar g = 0; g < 2; g++) begin : gLegacy
    logic wrThis;
    assign wrThis = (g == 0) ? strb.wrIe : strb.wrIp;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       legacyQ[g] <= '0;
      else if (wrThis) legacyQ[g] <= csrWData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mieQ  <= 1'b0;
      mpieQ <= 1'b0;
    end else if (strb.trapFire) begin
      mpieQ <= mieQ;
      mieQ  <= 1'b0;
    end else if (strb.retFire) begin
      mieQ  <= mpieQ;
      mpieQ <= 1'b1;
    end else if (strb.wrStatus) begin
      mieQ  <= csrWData[3];
      mpieQ <= csrWData[7];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              epcQ <= '0;
    else if (strb.trapFire) epcQ <= trapPc & ~XLEN'(1);
    else if (strb.wrEpc)    epcQ <= csrWData & ~XLEN'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeIrq <= 1'b0;
      causePil <= '0;
      causeId  <= '0;
    end else if (strb.trapFire) begin
      causeIrq <= 1'b1;
      causePil <= levelQ;
      causeId  <= trapId;
    end else if (strb.nxtFire) begin
      causeId  <= bestId;
    end else if (strb.wrCause) begin
      causeIrq <= csrWData[31];
      causePil <= csrWData[23:16];
      causeId  <= csrWData[ID_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              levelQ <= '0;
    else if (strb.trapFire) levelQ <= trapLevel;
    else if (strb.retFire)  levelQ <= causePil;
    else if (strb.nxtFire)  levelQ <= bestLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              threshQ <= '0;
    else if (strb.wrThresh) threshQ <= csrWData[LVL_W-1:0];
  end

  logic [XLEN-1:0] nxtValue;
  logic [XLEN-1:0] lvlWord;

  always_comb begin
    nxtValue = strb.nxtHit
             ? ({tvecBase, {BASE_LSB{1'b0}}} + {{OFS_PAD{1'b0}}, bestId, 2'b00})
             : '0;
    lvlWord  = {levelQ, 24'h0};
    unique case (csrAddr)
      ADDR_TVEC:   csrRData = {tvecBase, 4'h0, tvecMode};
      ADDR_IE:     csrRData = modeActive ? '0 : legacyQ[0];
      ADDR_IP:     csrRData = modeActive ? '0 : legacyQ[1];
      ADDR_STATUS: csrRData = {19'h0, 2'b11, 3'h0, mpieQ, 3'h0, mieQ, 3'h0};
      ADDR_EPC:    csrRData = epcQ;
      ADDR_CAUSE:  csrRData = {causeIrq, 7'h0, causePil, {ID_PAD{1'b0}}, causeId};
      ADDR_NEXT:   csrRData = nxtValue;
      ADDR_THRESH: csrRData = {24'h0, threshQ};
      ADDR_LVL:    csrRData = lvlWord;
      ADDR_ULVL:   csrRData = {24'h0, lvlWord[7:0]};
      default:     csrRData = '0;
    endcase
  end

  assign modeActive  = (tvecMode == MODE_VEC);
  assign curLevel    = levelQ;
  assign prevLevel   = causePil;
  assign threshLevel = threshQ;
  assign epcOut      = epcQ;
endmodule

// File: rtl/vic_csr_unit.sv
module vic_csr_unit
  import vic_csr_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       csrAddr,
  input  logic              csrWrEn,
  input  logic [31:0]       csrWData,
  input  logic              csrRdEn,
  output logic [31:0]       csrRData,
  input  logic              trapEn,
  input  logic [7:0]        trapLevel,
  input  logic [ID_W-1:0]   trapId,
  input  logic [31:0]       trapPc,
  input  logic              retEn,
  input  logic              bestValid,
  input  logic [7:0]        bestLevel,
  input  logic [ID_W-1:0]   bestId,
  output logic              modeActive,
  output logic [31:0]       epcOut,
  output logic              ackValid,
  output logic [ID_W-1:0]   ackId
);
  csrStrobe_t       strb;
  logic [LVL_W-1:0] curLevel;
  logic [LVL_W-1:0] prevLevel;
  logic [LVL_W-1:0] threshLevel;

  vic_csr_ctrl #(.ID_W(ID_W)) u_ctrl (
    .csrAddr(csrAddr), .csrWrEn(csrWrEn), .csrRdEn(csrRdEn),
    .trapEn(trapEn), .retEn(retEn),
    .bestValid(bestValid), .bestLevel(bestLevel), .bestId(bestId),
    .modeActive(modeActive), .prevLevel(prevLevel), .threshLevel(threshLevel),
    .strb(strb), .ackValid(ackValid), .ackId(ackId)
  );

  vic_csr_dpath #(.ID_W(ID_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .csrAddr(csrAddr), .csrWData(csrWData),
    .trapLevel(trapLevel), .trapId(trapId), .trapPc(trapPc),
    .bestLevel(bestLevel), .bestId(bestId), .csrRData(csrRData),
    .modeActive(modeActive), .curLevel(curLevel), .prevLevel(prevLevel),
    .threshLevel(threshLevel), .epcOut(epcOut)
  );
endmodule

// File: rtl/vic_csr_chk.sv
module vic_csr_chk
  import vic_csr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [11:0]      csrAddr,
  input logic             csrWrEn,
  input logic [31:0]      csrRData,
  input logic             trapEn,
  input logic [7:0]       trapLevel,
  input logic             retEn,
  input logic [7:0]       bestLevel,
  input logic             modeActive,
  input logic             ackValid,
  input logic [7:0]       curLevel,
  input logic [7:0]       prevLevel,
  input logic [7:0]       threshLevel
);
  assert_mode_from_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeActive) |-> $past(csrWrEn && csrAddr == ADDR_TVEC && !trapEn && !retEn));

  assert_legacy_ie_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeActive && csrAddr == ADDR_IE) |-> csrRData == 32'h0);

  assert_legacy_ip_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeActive && csrAddr == ADDR_IP) |-> csrRData == 32'h0);

  assert_entry_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapEn |=> (curLevel == $past(trapLevel) && prevLevel == $past(curLevel)));

  assert_return_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retEn && !trapEn) |=> curLevel == $past(prevLevel));

  assert_thresh_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trapEn || retEn) |=> threshLevel == $past(threshLevel));

  assert_ack_takes_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> curLevel == $past(bestLevel));
endmodule

bind vic_csr_unit vic_csr_chk u_chk (
  .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWrEn(csrWrEn), .csrRData(csrRData),
  .trapEn(trapEn), .trapLevel(trapLevel), .retEn(retEn), .bestLevel(bestLevel),
  .modeActive(modeActive), .ackValid(ackValid), .curLevel(curLevel),
  .prevLevel(prevLevel), .threshLevel(threshLevel)
);

// File: tb/sim_vic_csr_unit.sv
module sim_vic_csr_unit;
  import vic_csr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ID_W       = 8;
  localparam int N_VEC      = 26;

  logic            clk = 1'b0;
  logic            rstN;
  logic [11:0]     csrAddr;
  logic            csrWrEn, csrRdEn;
  logic [31:0]     csrWData, csrRData;
  logic            trapEn, retEn;
  logic [7:0]      trapLevel;
  logic [ID_W-1:0] trapId;
  logic [31:0]     trapPc;
  logic            bestValid;
  logic [7:0]      bestLevel;
  logic [ID_W-1:0] bestId;
  logic            modeActive, ackValid;
  logic [31:0]     epcOut;
  logic [ID_W-1:0] ackId;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  vic_csr_unit #(.ID_W(ID_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {isRead, reqNum, addr, wdata, expected}
  localparam logic [80:0] VEC [N_VEC] = '{
    {1'b0, 4'd2,  ADDR_IE,     32'h0000_00A5, 32'h0},           // R2
    {1'b1, 4'd2,  ADDR_IE,     32'h0,         32'h0000_00A5},   // R2
    {1'b0, 4'd3,  ADDR_IP,     32'h0000_00F0, 32'h0},           // R3
    {1'b1, 4'd3,  ADDR_IP,     32'h0,         32'h0000_00F0},   // R3
    {1'b0, 4'd1,  ADDR_TVEC,   32'h0000_1003, 32'h0},           // R1
    {1'b1, 4'd1,  ADDR_TVEC,   32'h0,         32'h0000_1003},   // R1
    {1'b0, 4'd2,  ADDR_IE,     32'h0000_FFFF, 32'h0},           // R2
    {1'b1, 4'd2,  ADDR_IE,     32'h0,         32'h0},           // R2
    {1'b0, 4'd3,  ADDR_IP,     32'h0000_0001, 32'h0},           // R3
    {1'b1, 4'd3,  ADDR_IP,     32'h0,         32'h0},           // R3
    {1'b0, 4'd1,  ADDR_TVEC,   32'h0000_2001, 32'h0},           // R1
    {1'b1, 4'd1,  ADDR_TVEC,   32'h0,         32'h0000_2003},   // R1
    {1'b0, 4'd1,  ADDR_TVEC,   32'h0000_2000, 32'h0},           // R1
    {1'b1, 4'd1,  ADDR_TVEC,   32'h0,         32'h0000_2000},   // R1
    {1'b1, 4'd2,  ADDR_IE,     32'h0,         32'h0000_00A5},   // R2
    {1'b1, 4'd3,  ADDR_IP,     32'h0,         32'h0000_00F0},   // R3
    {1'b0, 4'd1,  ADDR_TVEC,   32'h0000_103F, 32'h0},           // R1
    {1'b1, 4'd1,  ADDR_TVEC,   32'h0,         32'h0000_1003},   // R1
    {1'b0, 4'd7,  ADDR_THRESH, 32'h0000_01FF, 32'h0},           // R7
    {1'b1, 4'd7,  ADDR_THRESH, 32'h0,         32'h0000_00FF},   // R7
    {1'b0, 4'd4,  ADDR_LVL,    32'h1234_5678, 32'h0},           // R4
    {1'b1, 4'd4,  ADDR_LVL,    32'h0,         32'h0},           // R4
    {1'b1, 4'd4,  ADDR_ULVL,   32'h0,         32'h0},           // R4
    {1'b0, 4'd7,  ADDR_THRESH, 32'h0000_0010, 32'h0},           // R7
    {1'b0, 4'd5,  ADDR_STATUS, 32'h0000_0008, 32'h0},           // R5
    {1'b1, 4'd5,  ADDR_STATUS, 32'h0,         32'h0000_1808}    // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearCtl();
    csrWrEn = 1'b0; csrRdEn = 1'b0; trapEn = 1'b0; retEn = 1'b0;
    csrAddr = 12'h0; csrWData = 32'h0;
  endtask

  task automatic idle();
    @(negedge clk); clearCtl();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); clearCtl();
    csrWrEn = 1'b1; csrAddr = a; csrWData = d;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); clearCtl();
    csrRdEn = 1'b1; csrAddr = a;
    #1 check(req, csrRData, exp);
  endtask

  task automatic trap(input logic [7:0] lvl, input logic [ID_W-1:0] id, input logic [31:0] pc);
    @(negedge clk); clearCtl();
    trapEn = 1'b1; trapLevel = lvl; trapId = id; trapPc = pc;
  endtask

  task automatic ret();
    @(negedge clk); clearCtl();
    retEn = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    clearCtl();
    rstN = 1'b0; trapLevel = '0; trapId = '0; trapPc = '0;
    bestValid = 1'b0; bestLevel = '0; bestId = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    rdChk(ADDR_TVEC,   32'h0,         "R10");
    rdChk(ADDR_STATUS, 32'h0000_1800, "R10");
    rdChk(ADDR_THRESH, 32'h0,         "R10");
    rdChk(ADDR_LVL,    32'h0,         "R10");
    rdChk(ADDR_CAUSE,  32'h0,         "R10");
    check("R10", {31'h0, modeActive}, 32'h0);

    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][80]) rdChk(VEC[i][75:64], VEC[i][31:0], $sformatf("R%0d", VEC[i][79:76]));
      else            wr(VEC[i][75:64], VEC[i][63:32]);
      if (i == 5) check("R1", {31'h0, modeActive}, 32'h1);
      if (i == 13) check("R1", {31'h0, modeActive}, 32'h0);
    end

    // R5 first entry from level 0
    trap(8'h40, 8'd5, 32'h0000_8001);
    rdChk(ADDR_CAUSE,  32'h8000_0005, "R5");
    rdChk(ADDR_EPC,    32'h0000_8000, "R5");
    rdChk(ADDR_STATUS, 32'h0000_1880, "R5");
    rdChk(ADDR_LVL,    32'h4000_0000, "R5");
    rdChk(ADDR_THRESH, 32'h0000_0010, "R7");
    // nested entry saves the previous level
    trap(8'h60, 8'd7, 32'h0000_9000);
    rdChk(ADDR_CAUSE,  32'h8040_0007, "R5");
    rdChk(ADDR_LVL,    32'h6000_0000, "R5");
    check("R5", epcOut, 32'h0000_9000);
    // R6 return
    ret();
    rdChk(ADDR_LVL,    32'h4000_0000, "R6");
    rdChk(ADDR_STATUS, 32'h0000_1880, "R6");
    rdChk(ADDR_THRESH, 32'h0000_0010, "R7");

    // R8/R9 next-interrupt: saved level 0x40, threshold 0x10, base 0x1000
    bestValid = 1'b1; bestLevel = 8'h30; bestId = 8'd9;
    rdChk(ADDR_NEXT, 32'h0, "R8");
    check("R9", {31'h0, ackValid}, 32'h0);
    rdChk(ADDR_LVL, 32'h4000_0000, "R9");
    bestLevel = 8'h50;
    wr(ADDR_THRESH, 32'h50);
    rdChk(ADDR_NEXT, 32'h0, "R8");
    wr(ADDR_THRESH, 32'h20);
    rdChk(ADDR_NEXT, 32'h0000_1024, "R8");
    check("R9", {31'h0, ackValid}, 32'h1);
    check("R9", {24'h0, ackId}, 32'h9);
    rdChk(ADDR_LVL,   32'h5000_0000, "R9");
    rdChk(ADDR_CAUSE, 32'h8040_0009, "R9");
    bestValid = 1'b0;
    rdChk(ADDR_NEXT, 32'h0, "R8");
    // basic mode: no next-interrupt
    wr(ADDR_TVEC, 32'h0000_1000);
    bestValid = 1'b1; bestLevel = 8'h70; bestId = 8'd3;
    rdChk(ADDR_NEXT, 32'h0, "R8");
    check("R9", {31'h0, ackValid}, 32'h0);
    rdChk(ADDR_LVL, 32'h5000_0000, "R9");
    bestValid = 1'b0;

    // R10 reset mid-run
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rdChk(ADDR_THRESH, 32'h0, "R10");
    rdChk(ADDR_TVEC,   32'h0, "R10");
    rdChk(ADDR_IE,     32'h0, "R10");
    check("R10", {31'h0, modeActive}, 32'h0);
    idle();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule